// File: doc/BRIEF.md
# Embedded Erase and Program Engine with Status Polling

This block runs erase and program jobs on a small internal byte-wide register-file array. A command decoder upstream hands it one start request at a time. The request is one of three operations: wipe the whole array, wipe one page, or write one byte. While a job runs, the engine visits each affected byte in turn. It writes the target value (all-ones for the two erase kinds, the supplied byte for a program) and then reads the byte back to confirm it. If the read-back does not match, it writes the byte again.

Host reads go through a status multiplexer, and the read port stays usable during a job. While a job is running, a read that falls inside the region being worked on shows a status value on bit 7 instead of the stored bit. For an erase that value is 0. For a program it is the inverse of bit 7 of the byte being written. Bits 6:0 always come from the array. The status is available from the first cycle after the request is accepted. When the last byte has been confirmed, the engine returns to plain read mode by itself, so bit 7 then shows the true stored value. The host can therefore poll any address in the active region until bit 7 reads as expected.

The controller state machine has four states:
- `ST_IDLE`: waits for a request.
- `ST_WRITE`: writes the current byte.
- `ST_WAIT`: holds for `STEP_WAIT` settle cycles. This state is skipped when `STEP_WAIT` is 0.
- `ST_VERIFY`: compares the stored byte with the target.

The transitions are:
- `ST_IDLE` to `ST_WRITE` when a request is accepted.
- `ST_WRITE` to `ST_WAIT`, or straight to `ST_VERIFY` when `STEP_WAIT` is 0.
- `ST_WAIT` to `ST_VERIFY` when the settle count is done.
- `ST_VERIFY` back to `ST_WRITE` on a mismatch, or to move on to the next byte.
- `ST_VERIFY` to `ST_IDLE` once the last byte matches.

Top module: `erase_poll_engine`

## Requirements
- R1: A request is taken only when `busy` is low, `req_valid` is high and `req_op` is non-zero. The codes are 2'b01 whole-array erase, 2'b10 page erase and 2'b11 byte program. `busy` rises in the cycle after acceptance. A request with code 2'b00, or any request made while `busy` is high, has no effect.
- R2: Each affected byte takes 2+`STEP_WAIT` cycles. `busy` therefore stays high for exactly N*(2+`STEP_WAIT`) cycles. N is 2^`ADDR_W` for a whole-array erase, 2^`PAGE_W` for a page erase and 1 for a program.
- R3: After a whole-array erase, every byte reads 8'hFF.
- R4: A page erase sets to 8'hFF every byte whose address bits [`ADDR_W`-1:`PAGE_W`] equal those of `req_addr`. All other bytes are left unchanged.
- R5: While an erase is running, a read at an address inside the region being erased returns 0 on bit 7 and the current array contents on bits 6:0.
- R6: While a program is running, a read at the target address returns the inverse of `req_data[7]` on bit 7 and the current array contents on bits 6:0.
- R7: While `busy` is high, a read outside the active region returns the array contents.
- R8: While `busy` is low, `rd_data` equals the stored byte at `rd_addr`. The engine reaches this read mode by itself when the last byte is confirmed.
- R9: During reset and after it, `busy` is low and every byte of the array holds 8'h00.
- R10: A program stores `req_data` at `req_addr` and changes no other byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request strobe |
| req_op | input | 2 | Operation code: 01 whole-array erase, 10 page erase, 11 program |
| req_addr | input | ADDR_W | Program address, or any address inside the page to erase |
| req_data | input | 8 | Byte to program |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Read data, carrying status on bit 7 while a job runs |
| busy | output | 1 | High while a job runs |

## Verification
The bench builds the engine with `ADDR_W`=6, `PAGE_W`=3 and `STEP_WAIT`=2. That gives 64 bytes in eight pages of eight bytes. A whole-array erase then lasts 256 cycles, so every operation type, several full array sweeps and both page-boundary edges fit in a short run. The non-zero settle count exercises the `ST_WAIT` state. It also lengthens the window in which bits 6:0 of a polled byte can be seen before and after that byte is rewritten. Programs with bit 7 set and with bit 7 clear cover both polarities of the program status, and requests sent mid-job show that a busy engine does not take them.

// File: rtl/ep_pkg.sv
package ep_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_CHIP = 2'b01,
        OP_PAGE = 2'b10,
        OP_PROG = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WAIT,
        ST_VERIFY
    } st_e;

endpackage

// File: rtl/ep_array.sv
module ep_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_data,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [DATA_W-1:0] chk_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign host_data = cells[host_addr];
    assign chk_data  = cells[chk_addr];

endmodule

// File: rtl/ep_addr_gen.sv
module ep_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] first,
    input  logic [ADDR_W-1:0] final_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] cur,
    output logic              at_end
);
    logic [ADDR_W-1:0] end_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= '0;
            end_q <= '0;
        end else if (load) begin
            cur   <= first;
            end_q <= final_addr;
        end else if (step) begin
            cur   <= cur + 1'b1;
        end
    end

    assign at_end = (cur == end_q);

endmodule

// File: rtl/ep_poll_mux.sv
module ep_poll_mux #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              busy,
    input  ep_pkg::op_e       op,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              tgt_bit7,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_data,
    output logic [7:0]        rd_data
);
    import ep_pkg::*;

    logic hit;

    always_comb begin
        unique case (op)
            OP_NONE: hit = 1'b0;
            OP_CHIP: hit = 1'b1;
            OP_PAGE: hit = (rd_addr[ADDR_W-1:PAGE_W] == tgt_addr[ADDR_W-1:PAGE_W]);
            OP_PROG: hit = (rd_addr == tgt_addr);
        endcase
    end

    always_comb begin
        rd_data = arr_data;
        if (busy && hit) begin
            rd_data[7] = (op == OP_PROG) ? ~tgt_bit7 : 1'b0;
        end
    end

endmodule

// File: rtl/erase_poll_engine.sv
module erase_poll_engine #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 4,
    parameter int STEP_WAIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    import ep_pkg::*;

    localparam int  DATA_W   = 8;
    localparam int  WAIT_W   = (STEP_WAIT > 1) ? $clog2(STEP_WAIT) : 1;
    localparam bit  HAS_WAIT = (STEP_WAIT > 0);
    localparam int  OFS_W    = PAGE_W;

    st_e               state, state_nx;
    op_e               op_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic [DATA_W-1:0] tgt_data_q;

    logic              accept;
    logic [ADDR_W-1:0] span_lo, span_hi;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_last;
    logic              wr_en, step_en;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] host_raw, chk_raw;
    logic              verify_ok;
    logic              wait_done;

    assign accept = (state == ST_IDLE) && req_valid && (op_e'(req_op) != OP_NONE);

    // Region bounds for the incoming request
    always_comb begin
        span_lo = '0;
        span_hi = '1;
        unique case (op_e'(req_op))
            OP_NONE, OP_CHIP: begin
                span_lo = '0;
                span_hi = '1;
            end
            OP_PAGE: begin
                span_lo = {req_addr[ADDR_W-1:PAGE_W], {OFS_W{1'b0}}};
                span_hi = {req_addr[ADDR_W-1:PAGE_W], {OFS_W{1'b1}}};
            end
            OP_PROG: begin
                span_lo = req_addr;
                span_hi = req_addr;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_NONE;
            tgt_addr_q <= '0;
            tgt_data_q <= '0;
        end else if (accept) begin
            op_q       <= op_e'(req_op);
            tgt_addr_q <= req_addr;
            tgt_data_q <= req_data;
        end
    end

    // Settle counter, present only when a wait is configured
    generate
        if (HAS_WAIT) begin : g_wait
            logic [WAIT_W-1:0] wait_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wait_cnt <= '0;
                end else if (state == ST_WAIT) begin
                    wait_cnt <= wait_cnt + 1'b1;
                end else begin
                    wait_cnt <= '0;
                end
            end
            assign wait_done = (wait_cnt == WAIT_W'(STEP_WAIT - 1));
        end else begin : g_nowait
            assign wait_done = 1'b1;
        end
    endgenerate

    assign wr_val    = (op_q == OP_PROG) ? tgt_data_q : {DATA_W{1'b1}};
    assign verify_ok = (chk_raw == wr_val);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_WRITE;
            ST_WRITE:  state_nx = HAS_WAIT ? ST_WAIT : ST_VERIFY;
            ST_WAIT:   if (wait_done) state_nx = ST_VERIFY;
            ST_VERIFY: begin
                if (!verify_ok)    state_nx = ST_WRITE;
                else if (cur_last) state_nx = ST_IDLE;
                else               state_nx = ST_WRITE;
            end
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        busy    = 1'b1;
        wr_en   = 1'b0;
        step_en = 1'b0;
        unique case (state)
            ST_IDLE:   busy  = 1'b0;
            ST_WRITE:  wr_en = 1'b1;
            ST_WAIT:   ;
            ST_VERIFY: step_en = verify_ok && !cur_last;
        endcase
    end

    ep_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .first      (span_lo),
        .final_addr (span_hi),
        .step       (step_en),
        .cur        (cur_addr),
        .at_end     (cur_last)
    );

    ep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .waddr     (cur_addr),
        .wdata     (wr_val),
        .host_addr (rd_addr),
        .host_data (host_raw),
        .chk_addr  (cur_addr),
        .chk_data  (chk_raw)
    );

    ep_poll_mux #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mux (
        .busy     (busy),
        .op       (op_q),
        .tgt_addr (tgt_addr_q),
        .tgt_bit7 (tgt_data_q[7]),
        .rd_addr  (rd_addr),
        .arr_data (host_raw),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/ep_checker.sv
module ep_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              busy,
    input logic [1:0]        op_q,
    input logic [ADDR_W-1:0] tgt_addr_q,
    input logic [7:0]        tgt_data_q
);

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op != 2'b00) |=> busy); // R1

    AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req_valid && req_op != 2'b00)) |=> !busy); // R1

    AST_JOB_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_q)); // R1

    AST_CHIP_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == 2'b01) |-> !rd_data[7]); // R5

    AST_PROG_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == 2'b11 && rd_addr == tgt_addr_q) |-> (rd_data[7] == ~tgt_data_q[7])); // R6

    AST_CHIP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_q == 2'b01) |-> (rd_data == 8'hFF)); // R3

    AST_PROG_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_q == 2'b11 && rd_addr == tgt_addr_q) |-> (rd_data == tgt_data_q)); // R10

endmodule

bind erase_poll_engine ep_checker #(.ADDR_W(ADDR_W)) u_ep_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .busy       (busy),
    .op_q       (op_q),
    .tgt_addr_q (tgt_addr_q),
    .tgt_data_q (tgt_data_q)
);

// File: tb/test_erase_poll_engine.sv
`timescale 1ns/1ps
module test_erase_poll_engine;

    localparam int AW = 6;
    localparam int PW = 3;
    localparam int SW = 2;
    localparam int NB = 1 << AW;
    localparam int PB = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;

    always #2.5 clk = ~clk;

    erase_poll_engine #(.ADDR_W(AW), .PAGE_W(PW), .STEP_WAIT(SW)) i_erase_poll_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string idle_tag = "R8";

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model
    logic [7:0] m_mem [NB];
    bit         m_busy = 1'b0;
    int         m_cur, m_hi, m_phase, m_tgt;
    logic [1:0] m_op = 2'b00;
    logic [7:0] m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) m_mem[i] = 8'h00;
            m_busy = 1'b0;
        end else if (m_busy) begin
            if (m_phase == 0) begin
                m_mem[m_cur] = (m_op == 2'b11) ? m_data : 8'hFF;
                m_phase = 1;
            end else if (m_phase == SW + 1) begin
                if (m_cur == m_hi) m_busy = 1'b0;
                else begin
                    m_cur++;
                    m_phase = 0;
                end
            end else begin
                m_phase++;
            end
        end else if (req_valid && req_op != 2'b00) begin
            m_op = req_op;
            m_tgt = int'(req_addr);
            m_data = req_data;
            m_phase = 0;
            m_busy = 1'b1;
            if (req_op == 2'b01) begin
                m_cur = 0; m_hi = NB - 1;
            end else if (req_op == 2'b10) begin
                m_cur = (m_tgt / PB) * PB; m_hi = m_cur + PB - 1;
            end else begin
                m_cur = m_tgt; m_hi = m_tgt;
            end
        end
    end

    function automatic bit in_region(input int a);
        if (m_op == 2'b01) return 1'b1;
        if (m_op == 2'b10) return (a / PB) == (m_tgt / PB);
        if (m_op == 2'b11) return a == m_tgt;
        return 1'b0;
    endfunction

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            check(busy == 1'b0, "R9 busy in reset", int'(busy), 0);
        end else begin
            logic [7:0] exp;
            string      tag;
            int         a;
            a   = int'(rd_addr);
            exp = m_mem[a];
            tag = idle_tag;
            if (m_busy) begin
                if (in_region(a)) begin
                    if (m_op == 2'b11) begin
                        exp[7] = ~m_data[7];
                        tag = "R6";
                    end else begin
                        exp[7] = 1'b0;
                        tag = "R5";
                    end
                end else begin
                    tag = "R7";
                end
            end
            check(busy == m_busy, "R1 or R2 busy", int'(busy), int'(m_busy));
            check(rd_data == exp, tag, int'(rd_data), int'(exp));
        end
    end

    task automatic run_op(input logic [1:0] op, input int addr, input logic [7:0] data, input int poll);
        int n, expn;
        expn = (op == 2'b01) ? NB : (op == 2'b10) ? PB : 1;
        @(posedge clk); #1;
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_data = data;
        @(posedge clk); #1;
        req_valid = 1'b0;
        n = 0;
        while (busy) begin
            rd_addr = (n % 2 == 0) ? AW'(poll) : AW'($urandom);
            if (n == 1) begin
                // Request during a job: must be ignored (R1)
                req_valid = 1'b1; req_op = 2'b11; req_addr = AW'(addr ^ 1); req_data = 8'h00;
            end
            @(posedge clk); #1;
            req_valid = 1'b0;
            n++;
        end
        check(n == expn * (2 + SW), "R2 busy length", n, expn * (2 + SW));
    endtask

    task automatic sweep(input string tag);
        idle_tag = tag;
        for (int a = 0; a < NB; a++) begin
            @(posedge clk); #1;
            rd_addr = AW'(a);
        end
        @(posedge clk); #1;
        idle_tag = "R8";
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual hung expected idle");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        sweep("R9");
        run_op(2'b11, 5, 8'hA5, 5);
        sweep("R10");
        run_op(2'b11, 20, 8'h3C, 20);
        run_op(2'b11, 21, 8'h7E, 21);
        run_op(2'b11, 40, 8'h81, 40);
        sweep("R10");
        // Code 00 must not start a job (R1)
        @(posedge clk); #1;
        req_valid = 1'b1; req_op = 2'b00; req_addr = AW'(3);
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(busy == 1'b0, "R1 code 00 ignored", int'(busy), 0);
        run_op(2'b10, 21, 8'h00, 17);
        sweep("R4");
        run_op(2'b01, 0, 8'h00, 33);
        sweep("R3");
        run_op(2'b11, 63, 8'h12, 63);
        run_op(2'b11, 56, 8'h00, 56);
        run_op(2'b10, 60, 8'h00, 62);
        sweep("R4");
        run_op(2'b11, 0, 8'h55, 0);
        sweep("R8");
        summary();
        $finish;
    end

endmodule